// File: doc/BRIEF.md
# Serial Link Command Frame Receiver

This block is the command front end on the codec side of an AC'97-style serial link. The controller marks the start of each 256-bit output frame with a rising edge on the frame-sync line. It drives one serial data bit per bit-clock period. Everything changes on the rising edge of the bit clock, and this block samples on the falling edge. Each frame starts with a 16-bit tag slot, followed by a 20-bit command address slot and a 20-bit command data slot, all sent most significant bit first. The block collects the parts of these three slots that it needs. The audio slots after them pass by unused.

Once the data slot is complete, the block decides whether the frame asks this codec for a register read, for a register write, or for nothing. It bases the decision on the frame-valid and slot-valid tag bits and on a two-bit strapped codec identity. Identity zero makes the codec the primary device and any other value makes it a secondary device, and the two roles accept different tag patterns. An accepted command is presented as a one-period read or write strobe, together with a 7-bit register index and, for writes, a 16-bit value. A register file elsewhere consumes these.

Top module: `ac_cmd_rx`

## Requirements
- R1: A frame begins when the frame-sync input is sampled high on a falling bit-clock edge after being sampled low on the previous falling edge. Sync that stays high, including sync already high when reset is released, starts no frame. The data bit sampled on the next falling edge is frame bit 0, which is tag slot bit 15.
- R2: Frame bits 0..15 are tag slot bits 15..0, bits 16..35 are address slot bits 19..0, and bits 36..55 are data slot bits 19..0. Address bit 19 is the read flag (1 = read, 0 = write) and address bits 18:12 are the register index, with bit 18 as index bit 6. Data bits 19:4 are the write value, with bit 19 as value bit 15. Address bits 11:0, data bits 3:0 and tag bits 12:0 have no effect.
- R3: As primary (codec identity 00), with tag bits 15, 14 and 13 all set, the frame gives a read or a write according to the read flag.
- R4: As primary, with tag 15 set, tag 14 set and tag 13 clear, a read is accepted and a write is ignored.
- R5: As primary, a frame with tag 14 clear gives no strobe, whatever tag 13 is.
- R6: As secondary (identity 01, 10 or 11), only a frame with tag 15 set and tags 14 and 13 both clear is accepted, as a read or a write. Any other pattern of tags 14 and 13 is ignored.
- R7: A frame with tag 15 clear gives no strobe.
- R8: The read or write strobe is high for exactly one bit-clock period. It is set on the 57th falling edge after the edge that detected the frame start, which is one falling edge after data slot bit 0 was sampled. The register index and the write value are valid while the strobe is high.
- R9: A new sync rising edge partway through a frame restarts the count at frame bit 0. The cut-off frame gives no strobe.
- R10: While reset (active low) is applied, both strobes, the index and the value are zero. No strobe appears until the first frame start after reset is released.
- R11: The register index changes only with an accepted read or write. The write value changes only with an accepted write, so on a read it keeps its previous value.
- R12: The read strobe and the write strobe are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; the block samples on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_sync | input | 1 | Frame-sync line from the controller |
| link_sdo | input | 1 | Serial command and audio data from the controller |
| codec_id | input | 2 | Strapped codec identity, 00 = primary |
| rd_stb | output | 1 | One-period read request |
| wr_stb | output | 1 | One-period write request |
| reg_idx | output | 7 | Register index of the last accepted command |
| wr_val | output | 16 | Value of the last accepted write |

## Verification
The controller side of the bench changes its inputs on rising bit-clock edges, and it reads the outputs at those same rising edges, half a period after the falling edge that set them. The rising edge that raises sync counts as edge 0, and frame bit n is driven on rising edge n+1. An accepted command is therefore due at rising edge 58 of its frame, and exactly there. At every rising edge a reference model in the bench predicts all four outputs: the strobes from that edge count and from its own tag classification, the index and value from the last command it accepted. In this way a strobe one period early or late, one that lasts too long, or one from a cut-off frame fails a check.

// File: rtl/ac_cmd_pkg.sv
package ac_cmd_pkg;

  localparam int FRAME_BITS_D = 256;
  localparam int TAG_W_D      = 16;
  localparam int SLOT_W_D     = 20;
  localparam int IDX_W_D      = 7;
  localparam int DATA_W_D     = 16;

  typedef enum logic [1:0] {CMD_NONE, CMD_READ, CMD_WRITE} cmd_e;

  // Tag decode: frame valid, address slot valid, data slot valid,
  // strap identity and the read flag of the address slot.
  function automatic cmd_e classify(input logic fv, input logic av,
                                    input logic dv, input logic [1:0] id,
                                    input logic rd_flag);
    cmd_e res;
    res = CMD_NONE;
    if (fv) begin
      if (id == 2'b00) begin
        if (av && dv)       res = rd_flag ? CMD_READ : CMD_WRITE;
        else if (av && rd_flag) res = CMD_READ;
      end else if (!av && !dv) begin
        res = rd_flag ? CMD_READ : CMD_WRITE;
      end
    end
    return res;
  endfunction

  // First frame bit of a slot: slot 0 is the tag slot, later slots are SLOT_W wide.
  function automatic int slot_first(input int slot, input int tag_w, input int slot_w);
    return (slot == 0) ? 0 : tag_w + slot_w * (slot - 1);
  endfunction

endpackage

// File: rtl/ac_sync_edge.sv
module ac_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic sync_rise
);
  logic sync_q;

  // Reset value 1: sync already high at release is not an edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b1;
    else        sync_q <= sync_in;
  end

  assign sync_rise = sync_in && !sync_q;

endmodule

// File: rtl/ac_frame_counter.sv
module ac_frame_counter #(
  parameter int FRAME_BITS = 256,
  localparam int CW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic          active,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (restart) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) active <= 1'b0;
      else             cnt    <= cnt + 1'b1;
    end
  end

  AST_SYNC_RESTARTS: assert property (@(negedge clk) disable iff (!rst_n)
    restart |=> (active && cnt == '0)); // R9
  AST_CNT_STEP: assert property (@(negedge clk) disable iff (!rst_n)
    (active && !restart && cnt != LAST) |=> (active && cnt == $past(cnt) + 1'b1)); // R1

endmodule

// File: rtl/ac_slot_capture.sv
module ac_slot_capture #(
  parameter int FIRST = 0,
  parameter int KEEP  = 3,
  parameter int CW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [CW-1:0]   cnt,
  input  logic            bit_in,
  output logic [KEEP-1:0] q
);
  // The first KEEP bits of the slot land in q, MSB first; later bits are dropped.
  for (genvar g = 0; g < KEEP; g++) begin : g_bit
    localparam logic [CW-1:0] POS = CW'(FIRST + KEEP - 1 - g);
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)                        q[g] <= 1'b0;
      else if (active && cnt == POS)     q[g] <= bit_in;
    end
  end

endmodule

// File: rtl/ac_cmd_decode.sv
module ac_cmd_decode
  import ac_cmd_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              restart,
  input  logic [2:0]        tags,
  input  logic              rd_flag,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [1:0]        codec_id,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] wr_val
);
  cmd_e cmd;
  logic fire;

  assign cmd  = classify(tags[2], tags[1], tags[0], codec_id, rd_flag);
  assign fire = frame_done && !restart;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb  <= 1'b0;
      wr_stb  <= 1'b0;
      reg_idx <= '0;
      wr_val  <= '0;
    end else begin
      rd_stb <= fire && (cmd == CMD_READ);
      wr_stb <= fire && (cmd == CMD_WRITE);
      if (fire && cmd != CMD_NONE) reg_idx <= idx_in;
      if (fire && cmd == CMD_WRITE) wr_val <= data_in;
    end
  end

  AST_ONE_STROBE: assert property (@(negedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb)); // R12
  AST_RD_PULSE: assert property (@(negedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb); // R8
  AST_WR_PULSE: assert property (@(negedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R8
  AST_READ_KEEPS_VAL: assert property (@(negedge clk) disable iff (!rst_n)
    rd_stb |-> $stable(wr_val)); // R11

endmodule

// File: rtl/ac_cmd_rx.sv
module ac_cmd_rx
  import ac_cmd_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_BITS_D,
  parameter int TAG_W      = TAG_W_D,
  parameter int SLOT_W     = SLOT_W_D,
  parameter int IDX_W      = IDX_W_D,
  parameter int DATA_W     = DATA_W_D
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              link_sync,
  input  logic              link_sdo,
  input  logic [1:0]        codec_id,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] wr_val
);
  localparam int CW       = $clog2(FRAME_BITS);
  localparam int ADDR_KEEP = 1 + IDX_W;
  localparam int DONE_POS = slot_first(3, TAG_W, SLOT_W);
  localparam logic [CW-1:0] DONE_CNT = CW'(DONE_POS);

  // Named internal events
  logic          sync_rise;
  logic          active;
  logic [CW-1:0] cnt;
  logic          frame_done;
  logic [2:0]             tag_q;
  logic [ADDR_KEEP-1:0]   addr_q;
  logic [DATA_W-1:0]      data_q;

  ac_sync_edge u_edge (
    .clk(bit_clk), .rst_n(rst_n), .sync_in(link_sync), .sync_rise(sync_rise)
  );

  ac_frame_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk(bit_clk), .rst_n(rst_n), .restart(sync_rise), .active(active), .cnt(cnt)
  );

  ac_slot_capture #(.FIRST(slot_first(0, TAG_W, SLOT_W)), .KEEP(3), .CW(CW)) u_tag (
    .clk(bit_clk), .rst_n(rst_n), .active(active), .cnt(cnt), .bit_in(link_sdo), .q(tag_q)
  );

  ac_slot_capture #(.FIRST(slot_first(1, TAG_W, SLOT_W)), .KEEP(ADDR_KEEP), .CW(CW)) u_addr (
    .clk(bit_clk), .rst_n(rst_n), .active(active), .cnt(cnt), .bit_in(link_sdo), .q(addr_q)
  );

  ac_slot_capture #(.FIRST(slot_first(2, TAG_W, SLOT_W)), .KEEP(DATA_W), .CW(CW)) u_data (
    .clk(bit_clk), .rst_n(rst_n), .active(active), .cnt(cnt), .bit_in(link_sdo), .q(data_q)
  );

  assign frame_done = active && (cnt == DONE_CNT);

  ac_cmd_decode #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_dec (
    .clk(bit_clk), .rst_n(rst_n), .frame_done(frame_done), .restart(sync_rise),
    .tags(tag_q), .rd_flag(addr_q[ADDR_KEEP-1]), .idx_in(addr_q[IDX_W-1:0]),
    .data_in(data_q), .codec_id(codec_id),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .reg_idx(reg_idx), .wr_val(wr_val)
  );

  AST_STROBE_AFTER_DONE: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> $past(frame_done)); // R8
  AST_INVALID_NO_STROBE: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (frame_done && !tag_q[2]) |=> (!rd_stb && !wr_stb)); // R7
  AST_SECONDARY_TAGGED: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (frame_done && codec_id != 2'b00 && (tag_q[1] || tag_q[0])) |=> (!rd_stb && !wr_stb)); // R6
  AST_PRIMARY_WR_NEEDS_DATA: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (frame_done && codec_id == 2'b00 && !tag_q[0]) |=> !wr_stb); // R4
  AST_PRIMARY_NO_ADDR: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (frame_done && codec_id == 2'b00 && !tag_q[1]) |=> (!rd_stb && !wr_stb)); // R5
  AST_IDLE_AFTER_RESET: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !active |-> (!rd_stb && !wr_stb) or $past(active)); // R10

endmodule

// File: tb/ac_cmd_rx_tb.sv
module ac_cmd_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DUE_EDGE   = 58;
  localparam int WATCHDOG   = 200000;

  logic        bit_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        link_sync = 1'b0;
  logic        link_sdo  = 1'b0;
  logic [1:0]  codec_id  = 2'b00;
  logic        rd_stb, wr_stb;
  logic [6:0]  reg_idx;
  logic [15:0] wr_val;

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  ac_cmd_rx dut_i (
    .bit_clk(bit_clk), .rst_n(rst_n), .link_sync(link_sync), .link_sdo(link_sdo),
    .codec_id(codec_id), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .reg_idx(reg_idx), .wr_val(wr_val)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state
  int          edge_no = 1000;   // rising edges since the frame-start edge
  int          pend_kind = 0;    // 0 none, 1 read, 2 write
  logic [6:0]  pend_idx = '0;
  logic [15:0] pend_val = '0;
  logic [6:0]  exp_idx = '0;
  logic [15:0] exp_val = '0;
  string       cur_req = "R10";

  function automatic int model_kind(bit fv, bit av, bit dv, bit [1:0] id, bit rd);
    if (fv == 0) return 0;
    if (id != 2'b00) begin
      if (av || dv) return 0;
      return rd ? 1 : 2;
    end
    if (!av) return 0;
    if (rd) return 1;
    return dv ? 2 : 0;
  endfunction

  // One rising edge: compare the outputs (stable since the last falling edge), then drive.
  task automatic tick(input logic s, input logic d);
    logic er, ew;
    @(posedge bit_clk);
    edge_no++;
    er = (pend_kind == 1) && (edge_no == DUE_EDGE);
    ew = (pend_kind == 2) && (edge_no == DUE_EDGE);
    if (edge_no == DUE_EDGE && pend_kind != 0) exp_idx = pend_idx;
    if (ew) exp_val = pend_val;
    checks++;
    // R8 timing, R11 holding and R12 exclusivity are checked on every edge.
    if (rd_stb !== er || wr_stb !== ew || reg_idx !== exp_idx || wr_val !== exp_val) begin
      errors++;
      $display("FAIL %s edge %0d: rd=%0b wr=%0b idx=%h val=%h expected rd=%0b wr=%0b idx=%h val=%h",
               cur_req, edge_no, rd_stb, wr_stb, reg_idx, wr_val, er, ew, exp_idx, exp_val);
    end
    link_sync = s;
    link_sdo  = d;
  endtask

  // Send a frame of len bit-clock periods; edge 0 raises sync, edge n+1 carries frame bit n.
  task automatic send_frame(input string req, input bit [1:0] id, input bit fv,
                            input bit av, input bit dv, input bit rd,
                            input bit [6:0] idx, input bit [15:0] val, input int len);
    logic [0:255] fb;
    logic [15:0] s0;
    logic [19:0] s1, s2;
    s0 = {fv, av, dv, 13'($urandom)};           // R2: low tag bits are junk
    s1 = {rd, idx, 12'($urandom)};              // R2: reserved address bits junk
    s2 = {val, 4'($urandom)};                   // R2: reserved data bits junk
    fb = '0;
    fb[0:55] = {s0, s1, s2};
    for (int n = 56; n < 256; n++) fb[n] = 1'($urandom);
    codec_id = id;
    tick(1'b1, 1'($urandom));
    edge_no = 0;
    cur_req = req;
    pend_kind = (len > DUE_EDGE) ? model_kind(fv, av, dv, id, rd) : 0;
    pend_idx = idx;
    pend_val = val;
    for (int j = 1; j < len; j++) tick(j < 16, fb[j-1]);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge bit_clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state and no strobes before any frame start
    repeat (4) tick(1'b0, 1'b1);
    rst_n = 1'b1;
    cur_req = "R10";
    for (int k = 0; k < 80; k++) tick(1'b0, 1'($urandom));

    // R1: sync held high across reset release is not a frame start
    rst_n = 1'b0;
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b1);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int k = 0; k < 120; k++) tick(1'b1, 1'b1);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);

    // R3 primary read and write, R2 field layout, R11 read keeps value
    send_frame("R3", 2'b00, 1, 1, 1, 0, 7'h2A, 16'hBEEF, 256);
    send_frame("R3", 2'b00, 1, 1, 1, 1, 7'h15, 16'h1234, 256);
    send_frame("R11", 2'b00, 1, 1, 1, 1, 7'h33, 16'hFFFF, 256);
    send_frame("R2", 2'b00, 1, 1, 1, 0, 7'h7F, 16'h8000, 256);
    send_frame("R2", 2'b00, 1, 1, 1, 0, 7'h00, 16'h0001, 256);
    // R4 address-only tag: read accepted, write ignored
    send_frame("R4", 2'b00, 1, 1, 0, 1, 7'h41, 16'hAAAA, 256);
    send_frame("R4", 2'b00, 1, 1, 0, 0, 7'h42, 16'h5555, 256);
    // R5 address slot not tagged
    send_frame("R5", 2'b00, 1, 0, 1, 0, 7'h10, 16'hC0DE, 256);
    send_frame("R5", 2'b00, 1, 0, 0, 1, 7'h11, 16'hC0DE, 256);
    // R6 secondary identities
    send_frame("R6", 2'b01, 1, 0, 0, 0, 7'h05, 16'h0F0F, 256);
    send_frame("R6", 2'b10, 1, 0, 0, 1, 7'h06, 16'h1111, 256);
    send_frame("R6", 2'b11, 1, 0, 0, 0, 7'h07, 16'h7007, 256);
    send_frame("R6", 2'b11, 1, 1, 1, 0, 7'h08, 16'h2222, 256);
    send_frame("R6", 2'b01, 1, 1, 0, 1, 7'h09, 16'h3333, 256);
    send_frame("R6", 2'b10, 1, 0, 1, 0, 7'h0A, 16'h4444, 256);
    // R7 frame-valid clear
    send_frame("R7", 2'b00, 0, 1, 1, 0, 7'h12, 16'h9999, 256);
    send_frame("R7", 2'b01, 0, 0, 0, 1, 7'h13, 16'h8888, 256);
    // R9 mid-frame restart: cut-off frames give nothing, the next one is counted afresh
    send_frame("R9", 2'b00, 1, 1, 1, 0, 7'h55, 16'hDEAD, 30);
    send_frame("R9", 2'b00, 1, 1, 1, 0, 7'h56, 16'hFACE, 50);
    send_frame("R9", 2'b00, 1, 1, 1, 0, 7'h57, 16'hCAFE, 256);
    // R8 back-to-back accepted frames, then idle
    send_frame("R8", 2'b00, 1, 1, 1, 1, 7'h60, 16'h0000, 256);
    send_frame("R8", 2'b00, 1, 1, 1, 0, 7'h61, 16'h6161, 256);
    cur_req = "R8";
    for (int k = 0; k < 300; k++) tick(1'b0, 1'($urandom));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule